// File: doc/BRIEF.md
# Chip-Select Watchdog Supervisor

This block watches a host through the activity of a serial-bus chip-select line and supervises its reset. Only a falling edge on the active-low select restarts the watchdog, so a host that hangs with the select held either high or low is caught. The active-high reset output also follows a digital low-supply flag. After the supply returns, or after a watchdog expiry, reset is held for a fixed number of cycles that stands for a power-good settling time.

The block also decides whether internal nonvolatile writes may proceed. A write-enable latch is set and cleared by strobes from the command logic. It opens only after the select line has fallen once since the last reset. A write request taken while the select is low stays pending until the select rises, and then starts a self-timed write cycle of fixed length. Pulling the write-protect input low blocks new writes. If it falls while a write is still pending, the write is aborted. Once a write cycle has started, write-protect no longer affects it.

Top module: `cs_wdog_supervisor`

## Requirements
- R1: `rst_out` is high in every cycle in which `low_supply` is high, with no added delay.
- R2: After `rst_n` is released, or after the last clock edge that samples `low_supply` high, `rst_out` stays high for exactly HOLD_CYC further clock edges and then falls. A new `low_supply` pulse inside this window restarts the full hold.
- R3: The timeout L is chosen by `to_sel`: 0 selects TO_A, 1 selects TO_B and 2 selects TO_C. When the watchdog is on, `rst_out` rises at the (L+1)-th clock edge after the edge that sampled the last chip-select falling edge, unless that edge also samples a falling edge. A gap of exactly L+1 edges between falling edges therefore never resets.
- R4: Only a falling edge restarts the count. A select held low, or a rising edge followed by the select held high, still times out after L+1 edges.
- R5: With `wdt_en` low, or with `to_sel` equal to 3, the watchdog never asserts `rst_out`.
- R6: A watchdog reset keeps `rst_out` high for HOLD_CYC edges. The timeout count restarts from zero at the edge where reset ends.
- R7: After reset ends, `wel_set` has no effect until a chip-select falling edge has been sampled.
- R8: `wr_permit` is high exactly when the write-enable latch is set, `wp_n` is high and no write cycle is running. `wel_set` sets the latch and `wel_clr` clears it. When both strobes arrive in the same cycle, the clear wins.
- R9: A `wr_req` sampled while `cs_n` is low and `wr_permit` is high makes a write pending. The edge that samples the next rising edge of `cs_n` starts the write. `wr_busy` then stays high for exactly WRITE_CYC cycles, and the latch is cleared when the write ends.
- R10: If `wp_n` falls while `cs_n` is low and a write is pending, `wr_abort` is high for exactly one cycle after that edge. The pending write is dropped, so the following rise of `cs_n` starts no write.
- R11: Changes on `wp_n` during a running write neither shorten it nor raise `wr_abort`.
- R12: Any `rst_out` assertion clears the write-enable latch and the one-fall-seen condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low chip-select being watched |
| wp_n | input | 1 | Active-low write protect |
| low_supply | input | 1 | Digital low-supply flag, active high |
| to_sel | input | 2 | Timeout select: 0/1/2 pick TO_A/TO_B/TO_C, 3 disables the watchdog |
| wdt_en | input | 1 | Watchdog enable |
| wel_set | input | 1 | Strobe that sets the write-enable latch |
| wel_clr | input | 1 | Strobe that clears the write-enable latch |
| wr_req | input | 1 | Strobe that requests a nonvolatile write |
| rst_out | output | 1 | Active-high supervisor reset |
| wr_permit | output | 1 | Writes currently allowed |
| wr_abort | output | 1 | One-cycle pulse when a pending write is aborted |
| wr_busy | output | 1 | Internal write cycle running |

## Verification
The watchdog is driven with four patterns, one at a time for each timeout code:
- The select is held low, which shows that the level itself does not restart the count.
- The select rises once and then stays high, which shows that a rising edge does not restart the count.
- Falling edges arrive at random gaps up to and including L+1 edges, which exposes an off-by-one in the expiry edge.
- After each reset, the expiry time is measured again, which separates a count that restarts from one that continues.

Supply pulses, both single and repeated inside the hold window, show whether the hold restarts.

The write path is tested in four orders:
- `wp_n` toggles while no write is pending.
- `wp_n` falls during a pending write, which must abort it.
- `wp_n` falls during a running write, which must have no effect.
- `wel_set` arrives before the first select fall and again after a reset.

Together these separate the abort rule from the protect rule and from the arming rule.

// File: rtl/cs_wdog_supervisor.sv
module cs_wdog_supervisor #(
  parameter int TO_A      = 1000,
  parameter int TO_B      = 4000,
  parameter int TO_C      = 16000,
  parameter int HOLD_CYC  = 20000,
  parameter int WRITE_CYC = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wp_n,
  input  logic       low_supply,
  input  logic [1:0] to_sel,
  input  logic       wdt_en,
  input  logic       wel_set,
  input  logic       wel_clr,
  input  logic       wr_req,
  output logic       rst_out,
  output logic       wr_permit,
  output logic       wr_abort,
  output logic       wr_busy
);
  localparam int TAB  = (TO_A > TO_B) ? TO_A : TO_B;
  localparam int TMAX = (TAB > TO_C) ? TAB : TO_C;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int HW   = $clog2(HOLD_CYC + 1);
  localparam int WW   = $clog2(WRITE_CYC + 1);

  logic          cs_q, wp_q, armed, wel, pend;
  logic [CW-1:0] wd_cnt, lim;
  logic [HW-1:0] pg_cnt;
  logic [WW-1:0] wr_cnt;

  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire wp_fall  = wp_q & ~wp_n;
  wire wd_on    = wdt_en & (to_sel != 2'd3);

  always_comb begin
    case (to_sel)
      2'd0:    lim = CW'(TO_A);
      2'd1:    lim = CW'(TO_B);
      2'd2:    lim = CW'(TO_C);
      default: lim = '0;
    endcase
  end

  assign rst_out   = low_supply | (pg_cnt != HW'(HOLD_CYC));
  assign wr_busy   = (wr_cnt != '0);
  assign wr_permit = wel & wp_n & ~wr_busy;

  wire wd_fire   = wd_on & (wd_cnt >= lim) & ~cs_fall & ~rst_out;
  wire wr_start  = pend & cs_rise;
  wire wr_done   = (wr_cnt == WW'(1));
  wire abort_now = pend & ~cs_n & wp_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      wp_q <= 1'b1;
    end else begin
      cs_q <= cs_n;
      wp_q <= wp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wd_cnt <= '0;
    else if (rst_out | cs_fall | ~wd_on)
      wd_cnt <= '0;
    else if (wd_cnt < lim)
      wd_cnt <= wd_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pg_cnt <= '0;
    else if (low_supply | wd_fire)
      pg_cnt <= '0;
    else if (pg_cnt != HW'(HOLD_CYC))
      pg_cnt <= pg_cnt + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      wel      <= 1'b0;
      pend     <= 1'b0;
      wr_abort <= 1'b0;
    end else begin
      if (rst_out)      armed <= 1'b0;
      else if (cs_fall) armed <= 1'b1;

      if (rst_out | wel_clr | wr_done) wel <= 1'b0;
      else if (wel_set & armed)        wel <= 1'b1;

      if (rst_out | abort_now | wr_start)   pend <= 1'b0;
      else if (wr_req & ~cs_n & wr_permit)  pend <= 1'b1;

      wr_abort <= abort_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wr_cnt <= '0;
    else if (wr_start) wr_cnt <= WW'(WRITE_CYC);
    else if (wr_busy)  wr_cnt <= wr_cnt - WW'(1);
  end
endmodule

module cs_wdog_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic wp_n,
  input logic low_supply,
  input logic wdt_en,
  input logic rst_out,
  input logic wr_permit,
  input logic wr_abort,
  input logic wr_busy
);
  assert_lowsup_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |-> rst_out);

  assert_release_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (!low_supply && !$past(low_supply)));

  assert_wdog_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_out && !wdt_en && !low_supply) |=> (!rst_out || low_supply));

  assert_end_clears_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_busy) |-> !wr_permit);

  assert_abort_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> !wr_abort);

  assert_abort_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |-> !wr_busy);

  assert_permit_needs_wp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_permit && $past(wr_permit)) |-> ($past(wp_n) || wp_n));
endmodule

bind cs_wdog_supervisor cs_wdog_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .low_supply(low_supply),
  .wdt_en(wdt_en), .rst_out(rst_out), .wr_permit(wr_permit),
  .wr_abort(wr_abort), .wr_busy(wr_busy)
);

// File: tb/sim_cs_wdog_supervisor.sv
`timescale 1ns/1ps
module sim_cs_wdog_supervisor;
  localparam int TA = 20, TB = 35, TC = 50, HOLD = 30, WCYC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cs_n = 1'b1, wp_n = 1'b1, low_supply = 1'b0;
  logic [1:0] to_sel = 2'd3;
  logic wdt_en = 1'b0, wel_set = 1'b0, wel_clr = 1'b0, wr_req = 1'b0;
  logic rst_out, wr_permit, wr_abort, wr_busy;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cs_wdog_supervisor #(.TO_A(TA), .TO_B(TB), .TO_C(TC), .HOLD_CYC(HOLD), .WRITE_CYC(WCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .low_supply(low_supply),
    .to_sel(to_sel), .wdt_en(wdt_en), .wel_set(wel_set), .wel_clr(wel_clr),
    .wr_req(wr_req), .rst_out(rst_out), .wr_permit(wr_permit),
    .wr_abort(wr_abort), .wr_busy(wr_busy));

  function automatic int lim_of(input logic [1:0] s);
    return (s == 2'd0) ? TA : (s == 2'd1) ? TB : TC;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wait_rst_low(output int n);
    n = 0;
    while (rst_out && n < 5000) begin tick; n++; end
  endtask

  task automatic wait_rst_high(output int n);
    n = 0;
    while (!rst_out && n < 5000) begin tick; n++; end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    report;
  end

  initial begin
    int n;
    bit bad;
    void'($urandom(32'd4711));
    #12;
    check("R2 reset state rst_out", rst_out, 1);
    check("R8 reset state permit", wr_permit, 0);
    check("R9 reset state busy", wr_busy, 0);
    check("R10 reset state abort", wr_abort, 0);
    tick; rst_n = 1'b1;
    wait_rst_low(n);
    check("R2 power-up hold", n, HOLD);

    // R7: not armed yet
    wel_set = 1; tick; wel_set = 0; tick;
    check("R7 wel_set before first fall", wr_permit, 0);
    cs_n = 0; tick; cs_n = 1; tick;
    wel_set = 1; tick; wel_set = 0;
    check("R8 latch set after arming", wr_permit, 1);
    wp_n = 0; tick;
    check("R8 permit low with wp low", wr_permit, 0);
    wp_n = 1; tick;
    check("R8 latch kept across wp", wr_permit, 1);
    wel_set = 1; wel_clr = 1; tick; wel_set = 0; wel_clr = 0;
    check("R8 clear wins over set", wr_permit, 0);

    // R9 write cycle
    wel_set = 1; tick; wel_set = 0;
    cs_n = 0; tick;
    wr_req = 1; tick; wr_req = 0;
    check("R9 no busy before cs rise", wr_busy, 0);
    cs_n = 1; tick;
    n = 0;
    while (wr_busy && n < 1000) begin n++; tick; end
    check("R9 busy length", n, WCYC);
    check("R9 latch cleared after write", wr_permit, 0);

    // R10 abort
    wel_set = 1; tick; wel_set = 0;
    cs_n = 0; tick;
    wr_req = 1; tick; wr_req = 0;
    wp_n = 0; tick;
    check("R10 abort pulse", wr_abort, 1);
    tick;
    check("R10 abort one cycle", wr_abort, 0);
    wp_n = 1; cs_n = 1; tick;
    check("R10 no write after abort", wr_busy, 0);

    // R11 wp during running write
    cs_n = 0; tick;
    wr_req = 1; tick; wr_req = 0;
    cs_n = 1; tick;
    check("R11 write started", wr_busy, 1);
    n = 1; bad = 0;
    wp_n = 0; tick;
    while (wr_busy && n < 1000) begin
      if (wr_abort) bad = 1;
      n++; tick;
      if (n == 5) wp_n = 1;
    end
    check("R11 busy length with wp change", n, WCYC);
    check("R11 no abort during write", bad, 0);

    // R1 / R12 / R2
    wel_set = 1; tick; wel_set = 0;
    check("R12 latch set before supply drop", wr_permit, 1);
    low_supply = 1; #1;
    check("R1 immediate reset", rst_out, 1);
    bad = 0;
    for (int i = 0; i < 5; i++) begin tick; if (!rst_out) bad = 1; end
    check("R1 reset held while low", bad, 0);
    check("R12 latch cleared by reset", wr_permit, 0);
    low_supply = 0;
    wait_rst_low(n);
    check("R2 hold after supply good", n, HOLD);
    low_supply = 1; tick; low_supply = 0;
    for (int i = 0; i < 10; i++) tick;
    low_supply = 1; tick; low_supply = 0;
    wait_rst_low(n);
    check("R2 hold restarts on glitch", n, HOLD);
    wel_set = 1; tick; wel_set = 0; tick;
    check("R12 arming cleared by reset", wr_permit, 0);

    // R3 / R4 / R6 per timeout code
    for (int s = 0; s < 3; s++) begin
      int l;
      l = lim_of(2'(s));
      wdt_en = 0; tick;
      to_sel = 2'(s); wdt_en = 1; cs_n = 0; tick;
      wait_rst_high(n);
      check($sformatf("R3 timeout sel %0d stuck low (R4)", s), n, l + 1);
      wait_rst_low(n);
      check($sformatf("R6 watchdog reset length sel %0d", s), n, HOLD);
      wait_rst_high(n);
      check($sformatf("R6 count restarts after reset sel %0d", s), n, l + 1);
      wait_rst_low(n);
      cs_n = 1;
      wait_rst_high(n);
      check($sformatf("R4 rise then stuck high sel %0d", s), n, l + 1);
      wait_rst_low(n);

      // R3 random gaps up to the boundary
      wdt_en = 0; tick;
      wdt_en = 1; cs_n = 0; tick;
      bad = 0;
      for (int r = 0; r < 20; r++) begin
        int g, a;
        g = (r == 0) ? l + 1 : $urandom_range(l + 1, 2);
        a = $urandom_range(g - 1, 1);
        for (int k = 0; k < a - 1; k++) begin tick; if (rst_out) bad = 1; end
        cs_n = 1;
        for (int k = 0; k < g - a; k++) begin tick; if (rst_out) bad = 1; end
        cs_n = 0; tick; if (rst_out) bad = 1;
      end
      check($sformatf("R3 gaps up to L+1 never reset sel %0d", s), bad, 0);
      cs_n = 1; wdt_en = 0; tick;
    end

    // R5 disabled watchdog
    to_sel = 2'd3; wdt_en = 1; cs_n = 0; tick;
    bad = 0;
    for (int i = 0; i < 3 * TC; i++) begin tick; if (rst_out) bad = 1; end
    check("R5 code 3 disables", bad, 0);
    to_sel = 2'd0; wdt_en = 0; cs_n = 1; tick;
    bad = 0;
    for (int i = 0; i < 3 * TC; i++) begin tick; if (rst_out) bad = 1; end
    check("R5 enable low disables", bad, 0);

    report;
  end
endmodule